// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block sits between a host processor and a system-management microcontroller. The host reaches it through a small 32-bit register bus. It writes up to four payload words into an outgoing buffer, then writes a command word. That command write marks the mailbox busy, latches the word and rings a one-cycle doorbell toward the controller. The controller reads the latched word and the payload from the block's outputs. It can load response words into an incoming buffer. It ends the exchange with a one-cycle done pulse that carries an error flag and an 8-bit error code.

The command word holds its own choice of notification. If bit 8 is set, completion raises a level interrupt to the host. The interrupt stays up until the host reads the status word. If bit 8 is clear, no interrupt is raised and the host polls the busy bit. The status word packs busy, error, the echoed command id, a fixed initiator id and the last error code.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, `host_irq` and `db_valid` are 0 and the status word (offset 0x04) reads `{8'h00, 8'h00, INIT_ID, 4'h0, 2'b00, 1'b0, 1'b0}`.
- R2: A host write to offset 0x00 while not busy makes busy (status bit 0) read 1 from the next cycle. It gives a `db_valid` pulse of exactly one cycle, with `db_cmd` equal to the written word. Status bits [7:4] then echo bits [15:12] of that word.
- R3: A host write to offset 0x00 while busy is dropped: no doorbell pulse, and `db_cmd` and status bits [7:4] keep their values.
- R4: A `ctl_done` pulse while busy clears busy on the next cycle. It latches `ctl_err` into status bit 1 and `ctl_code` into status bits [23:16]. Status bits [31:24] and [3:2] always read 0, and bits [15:8] always read INIT_ID.
- R5: If bit 8 of the latched command is 1, completion sets `host_irq`. It holds at 1 until the cycle after a host read of offset 0x04.
- R6: If bit 8 of the latched command is 0, completion leaves `host_irq` at 0.
- R7: A host word write to offset 0x80 + 4k (k = 0..3) sets `tx_payload[32k+31:32k]`. The size field, bits [23:16] of the command, reaches the controller unchanged in `db_cmd`.
- R8: Offsets 0x90 + 4k read back the word that the controller loaded with `ctl_fill_we`, `ctl_fill_idx` = k. With `hb_byte` = 1, a read at 0x90 + n returns byte n of the buffer (little-endian within each word) in bits [7:0], and bits [31:8] read 0.
- R9: Reads of the command register, the outgoing buffer or any unmapped offset return 0. Host writes to offset 0x04 or to the incoming buffer change nothing that can be read back.
- R10: Accepting a new command clears the error bit and error code. A `ctl_done` pulse while not busy changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_byte | input | 1 | Host read returns one byte instead of a word |
| hb_addr | input | ADDR_W | Host byte offset |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, valid while hb_rd is high |
| host_irq | output | 1 | Completion interrupt to the host, level |
| db_valid | output | 1 | Doorbell pulse to the controller |
| db_cmd | output | 32 | Latched command word |
| tx_payload | output | 32*WORDS | Outgoing payload buffer |
| ctl_done | input | 1 | Controller completion pulse |
| ctl_err | input | 1 | Error flag carried with ctl_done |
| ctl_code | input | 8 | Error code carried with ctl_done |
| ctl_fill_we | input | 1 | Controller write into the response buffer |
| ctl_fill_idx | input | $clog2(WORDS) | Response buffer word index |
| ctl_fill_data | input | 32 | Response word |

## Verification
The bench runs three commands. The first has the interrupt flag clear and no error, and shows polling without an interrupt. The second has the flag set and an error with a nonzero code, and shows the interrupt being held and then cleared by the status read. The third follows an error, and shows the error being cleared when a command is accepted. A command written while busy and a done pulse while idle check that these two stimuli are dropped. Word and byte reads of the response buffer at mixed lanes check the byte order. Reads of write-only and unmapped offsets, and writes to read-only ones, check the address decode.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int          ADDR_W    = 8,
  parameter int          WORDS     = 4,
  parameter int unsigned WBUF_BASE = 32'h80,
  parameter int unsigned RBUF_BASE = 32'h90,
  parameter logic [7:0]  INIT_ID   = 8'h2C,
  localparam int         IW        = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hb_wr,
  input  logic                  hb_rd,
  input  logic                  hb_byte,
  input  logic [ADDR_W-1:0]     hb_addr,
  input  logic [31:0]           hb_wdata,
  output logic [31:0]           hb_rdata,
  output logic                  host_irq,
  output logic                  db_valid,
  output logic [31:0]           db_cmd,
  output logic [32*WORDS-1:0]   tx_payload,
  input  logic                  ctl_done,
  input  logic                  ctl_err,
  input  logic [7:0]            ctl_code,
  input  logic                  ctl_fill_we,
  input  logic [IW-1:0]         ctl_fill_idx,
  input  logic [31:0]           ctl_fill_data
);
  localparam int unsigned SPAN = 4 * WORDS;

  logic        busy, err, irq_q, db_q;
  logic [7:0]  code;
  logic [31:0] cmd_q;
  logic [31:0] rbuf [WORDS];
  logic [31:0] a32;
  logic [IW-1:0] widx;
  logic        cmd_wr, sts_hit, sts_rd, issue, done_ok, in_wb, in_rb;
  logic [31:0] rword, status;

  assign a32     = 32'(hb_addr);
  assign widx    = hb_addr[IW+1:2];
  assign cmd_wr  = hb_wr && (a32 == 32'h0);
  assign sts_hit = (a32 == 32'h4);
  assign sts_rd  = hb_rd && sts_hit;
  assign issue   = cmd_wr && !busy;
  assign done_ok = ctl_done && busy;
  assign in_wb   = (a32 >= WBUF_BASE) && (a32 < WBUF_BASE + SPAN);
  assign in_rb   = (a32 >= RBUF_BASE) && (a32 < RBUF_BASE + SPAN);

  assign host_irq = irq_q;
  assign db_valid = db_q;
  assign db_cmd   = cmd_q;
  assign status   = {8'h00, code, INIT_ID, cmd_q[15:12], 2'b00, err, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      err   <= 1'b0;
      code  <= 8'h00;
      cmd_q <= 32'h0;
      db_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      db_q <= issue;
      if (issue) begin
        busy  <= 1'b1;
        cmd_q <= hb_wdata;
        err   <= 1'b0;
        code  <= 8'h00;
      end else if (done_ok) begin
        busy <= 1'b0;
        err  <= ctl_err;
        code <= ctl_code;
      end
      if (done_ok && cmd_q[8]) irq_q <= 1'b1;
      else if (sts_rd)         irq_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_buf
    logic [31:0] wq;
    always_ff @(posedge clk) begin
      if (!rst_n) wq <= 32'h0;
      else if (hb_wr && in_wb && widx == IW'(k)) wq <= hb_wdata;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) rbuf[k] <= 32'h0;
      else if (ctl_fill_we && ctl_fill_idx == IW'(k)) rbuf[k] <= ctl_fill_data;
    end
    assign tx_payload[32*k +: 32] = wq;
  end

  assign rword = rbuf[widx];

  always_comb begin
    hb_rdata = 32'h0;
    if (hb_rd) begin
      if (sts_hit)      hb_rdata = status;
      else if (in_rb)   hb_rdata = hb_byte ? {24'h0, rword[8*hb_addr[1:0] +: 8]} : rword;
    end
  end

  a_r2_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> (busy && db_valid && db_cmd == $past(hb_wdata)));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |=> !db_valid);
  a_r3_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (!db_valid && $stable(db_cmd)));
  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_done) |=> !busy);
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !sts_rd) |=> host_irq);
  a_r6_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_done && !db_cmd[8] && !host_irq) |=> !host_irq);
  a_r10_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_done && !cmd_wr) |=> ($stable(err) && $stable(code)));
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  localparam logic [7:0] IID = 8'h2C;
  logic clk = 0, rst_n = 0;
  logic hb_wr = 0, hb_rd = 0, hb_byte = 0;
  logic [7:0] hb_addr = 0;
  logic [31:0] hb_wdata = 0, hb_rdata, db_cmd, ctl_fill_data = 0;
  logic host_irq, db_valid, ctl_done = 0, ctl_err = 0, ctl_fill_we = 0;
  logic [7:0] ctl_code = 0;
  logic [1:0] ctl_fill_idx = 0;
  logic [127:0] tx_payload;
  int checks = 0, errors = 0, db_cnt = 0;
  logic [31:0] exp_q[$], db_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ipc_mailbox #(.INIT_ID(IID)) i_ipc_mailbox (
    .clk, .rst_n, .hb_wr, .hb_rd, .hb_byte, .hb_addr, .hb_wdata, .hb_rdata,
    .host_irq, .db_valid, .db_cmd, .tx_payload, .ctl_done, .ctl_err, .ctl_code,
    .ctl_fill_we, .ctl_fill_idx, .ctl_fill_data);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (hb_rd) begin
    if (exp_q.size() == 0) chk("monitor: read without expectation", 1, 0);
    else chk(tag_q.pop_front(), hb_rdata, exp_q.pop_front());
  end

  always @(negedge clk) if (rst_n && db_valid) begin
    db_cnt++;
    if (db_q.size() == 0) chk("R3 unexpected doorbell", db_cmd, 32'hx);
    else chk("R2 doorbell command", db_cmd, db_q.pop_front());
  end

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    hb_addr = a; hb_wdata = d; hb_wr = 1;
    @(posedge clk); #1 hb_wr = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic b, logic [31:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    hb_addr = a; hb_byte = b; hb_rd = 1;
    @(posedge clk); #1 hb_rd = 0; hb_byte = 0;
  endtask

  task automatic issue(logic [31:0] c, logic expect_db);
    if (expect_db) db_q.push_back(c);
    bus_wr(8'h00, c);
  endtask

  task automatic finish_cmd(logic e, logic [7:0] c);
    ctl_done = 1; ctl_err = e; ctl_code = c;
    @(posedge clk); #1 ctl_done = 0; ctl_err = 0; ctl_code = 0;
  endtask

  task automatic fill(logic [1:0] i, logic [31:0] d);
    ctl_fill_we = 1; ctl_fill_idx = i; ctl_fill_data = d;
    @(posedge clk); #1 ctl_fill_we = 0;
  endtask

  function automatic logic [31:0] sts(logic [7:0] code, logic [3:0] id, logic e, logic b);
    return {8'h00, code, IID, id, 2'b00, e, b};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 irq after reset", {31'b0, host_irq}, 0);
    chk("R1 doorbell after reset", {31'b0, db_valid}, 0);
    bus_rd(8'h04, 0, sts(8'h00, 4'h0, 0, 0), "R1 status after reset");

    bus_wr(8'h80, 32'h1111_0000); bus_wr(8'h84, 32'h2222_0001);
    bus_wr(8'h88, 32'h3333_0002); bus_wr(8'h8C, 32'h4444_0003);
    chk("R7 payload word0", tx_payload[31:0],   32'h1111_0000);
    chk("R7 payload word3", tx_payload[127:96], 32'h4444_0003);

    issue(32'h0008_3027, 1);
    bus_rd(8'h04, 0, sts(8'h00, 4'h3, 0, 1), "R2 busy and id");
    issue(32'h0010_7155, 0);
    bus_rd(8'h04, 0, sts(8'h00, 4'h3, 0, 1), "R3 command while busy dropped");
    chk("R3 db_cmd kept", db_cmd, 32'h0008_3027);
    chk("R7 size field to controller", {24'b0, db_cmd[23:16]}, 32'h08);

    fill(2'd0, 32'hDDCC_BBAA); fill(2'd2, 32'h8765_4321);
    finish_cmd(0, 8'h00);
    chk("R6 no irq in poll mode", {31'b0, host_irq}, 0);
    bus_rd(8'h04, 0, sts(8'h00, 4'h3, 0, 0), "R4 busy cleared");
    chk("R6 no irq after status read", {31'b0, host_irq}, 0);

    bus_rd(8'h90, 0, 32'hDDCC_BBAA, "R8 word read 0");
    bus_rd(8'h98, 0, 32'h8765_4321, "R8 word read 2");
    bus_rd(8'h91, 1, 32'h0000_00BB, "R8 byte read lane1");
    bus_rd(8'h93, 1, 32'h0000_00DD, "R8 byte read lane3");
    bus_rd(8'h98, 1, 32'h0000_0021, "R8 byte read lane0 word2");

    issue(32'h0004_9155, 1);
    finish_cmd(1, 8'hA5);
    chk("R5 irq raised", {31'b0, host_irq}, 1);
    @(posedge clk); #1;
    chk("R5 irq held", {31'b0, host_irq}, 1);
    bus_rd(8'h04, 0, sts(8'hA5, 4'h9, 1, 0), "R4 error and code latched");
    chk("R5 irq cleared by status read", {31'b0, host_irq}, 0);

    finish_cmd(0, 8'h33);
    bus_rd(8'h04, 0, sts(8'hA5, 4'h9, 1, 0), "R10 done while idle ignored");

    issue(32'h0000_6001, 1);
    bus_rd(8'h04, 0, sts(8'h00, 4'h6, 0, 1), "R10 error cleared on issue");
    finish_cmd(0, 8'h00);

    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_wr(8'h94, 32'hFFFF_FFFF);
    bus_rd(8'h04, 0, sts(8'h00, 4'h6, 0, 0), "R9 status write ignored");
    bus_rd(8'h94, 0, 32'h0, "R9 read buffer write ignored");
    bus_rd(8'h00, 0, 32'h0, "R9 command read zero");
    bus_rd(8'h84, 0, 32'h0, "R9 write buffer read zero");
    bus_rd(8'h40, 0, 32'h0, "R9 unmapped read zero");

    repeat (2) @(posedge clk); #1;
    chk("R3 doorbell count", db_cnt, 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule